// File: doc/BRIEF.md
# NAND Flash Bus Strobe Timing Engine

This block turns single bus-cycle requests from a register-style host port into correctly timed strobe sequences on an 8-bit NAND flash device. The host loads a 32-bit timing word that holds separate setup, pulse-width, hold and ready-delay counts for read-type and write-type cycles. It then requests one cycle at a time: a command latch, an address latch, a data write or a data read. The engine drives the command and address latch lines, the active-low write and read strobes, and the data bus with its output enable. It captures read data and reports when it is idle again.

Each cycle moves through a setup phase, a pulse phase and a hold phase. During setup the control lines and data are already driven but the strobe is still inactive. The strobe is low for the pulse phase. During hold it is high again while the lines stay driven. An optional ready-sample delay comes after the hold phase. While this delay runs the bus is quiet but the engine stays busy. A configuration bit can hold chip enable low between cycles. The device ready/busy pin is brought back in to the host as a synchronized status bit. A software reset clears the configuration and stops any cycle in progress.

Top module: `nand_strobe_engine`

## Requirements
- R1: Read cycles (kind 2'b11) take their timing from timing word bits: setup [3:0], hold [7:4], pulse width [11:8], ready delay [15:12]. A setup, hold or width value N lasts N+1 clocks, so 0 gives 1 clock and 15 gives 16 clocks.
- R2: Write-type cycles (kinds 2'b00, 2'b01, 2'b10) take their timing from setup [19:16], hold [23:20], pulse width [27:24] and ready delay [31:28], with the same N+1 rule.
- R3: After the hold phase, a ready-delay value N keeps busy high for exactly 2*N further clocks. During those clocks chip enable and all strobes and latch lines are inactive. A value of 0 adds no clocks.
- R4: Kind encoding is 2'b00 command (CLE high), 2'b01 address (ALE high), 2'b10 data write and 2'b11 data read. The latch line and chip enable (low) are active through setup, pulse and hold only. For the three write-type kinds the request data is driven on the bus with output enable high over the same span. For reads the output enable stays low.
- R5: The cycle's strobe (nWE for write types, nRE for reads) is high in setup, low for the whole pulse phase and high in hold. The other strobe stays high, and the two strobes are never low together.
- R6: Read data is sampled on the clock edge that ends the pulse phase. It appears on rd_data together with a single-clock rd_valid pulse.
- R7: A request is accepted only when the engine is idle, and busy rises on the next clock. A request made while busy is ignored and does not change the cycle in progress or start a new one.
- R8: With the chip-enable hold bit set, nand_ce_n stays low while idle. When the bit is cleared, nand_ce_n is high whenever no cycle phase is active.
- R9: dev_ready follows the ready/busy pin (1 means ready) after SYNC_STAGES clocks.
- R10: soft_rst returns the engine to idle on the next clock. It also clears the timing word to zero and clears the chip-enable hold bit.
- R11: After reset the engine is idle with both strobes high, latch lines low, output enable low, chip enable high and rd_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software reset: clears configuration, aborts cycle |
| cfg_wr | input | 1 | Load timing word and chip-enable hold bit |
| cfg_timing | input | 32 | Timing word (eight 4-bit fields) |
| cfg_ce_force | input | 1 | Chip-enable hold bit value |
| req_valid | input | 1 | Cycle request |
| req_kind | input | 2 | Cycle kind: 00 command, 01 address, 10 write, 11 read |
| req_wdata | input | 8 | Command, address or write data byte |
| busy | output | 1 | Cycle or ready delay in progress |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-clock pulse with new read data |
| dev_ready | output | 1 | Synchronized device ready status |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus output |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input |
| nand_rb | input | 1 | Device ready/busy pin, 1 = ready |

## Verification
Some properties are checked by the assertions on every cycle. The two strobes are never low together, and CLE and ALE never rise together. A latch line always comes with chip enable and the data output enable, and the write strobe is never low without the bus being driven. No strobe moves while idle. rd_valid lasts one clock and always follows a read strobe. busy only rises after a request, and a software reset forces idle. The exact phase lengths come from each field's N+1 count, and the ready delay is 2*N. Checking them, and seeing that a request made mid-cycle changes nothing, needs the bench's scenarios. The same holds for read-data capture, the chip-enable hold bit and ready-pin tracking. The bench measures those phase by phase at the pins.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'b00,
    KIND_ADDR  = 2'b01,
    KIND_WDATA = 2'b10,
    KIND_RDATA = 2'b11
  } cyc_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_PULSE = 3'd2,
    PH_HOLD  = 3'd3,
    PH_WAIT  = 3'd4
  } phase_e;

  // Field slot order inside one timing group (read group low, write group high)
  localparam int SLOT_SETUP = 0;
  localparam int SLOT_HOLD  = 1;
  localparam int SLOT_WIDTH = 2;
  localparam int SLOT_DELAY = 3;
  localparam int SLOTS_PER_GROUP = 4;

  function automatic logic kind_is_read(input cyc_kind_e k);
    return (k == KIND_RDATA);
  endfunction

endpackage

// File: rtl/nand_sync_chain.sv
module nand_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/nand_timing_regs.sv
module nand_timing_regs #(
  parameter int TIMING_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                cfg_wr,
  input  logic [TIMING_W-1:0] cfg_timing,
  input  logic                cfg_ce_force,
  output logic [TIMING_W-1:0] timing_word,
  output logic                ce_force
);

  logic [TIMING_W-1:0] timing_q, timing_d;
  logic                ce_q, ce_d;
  logic                load_en;

  assign load_en = soft_rst | cfg_wr;

  always_comb begin
    if (soft_rst) begin
      timing_d = '0;
      ce_d     = 1'b0;
    end else begin
      timing_d = cfg_timing;
      ce_d     = cfg_ce_force;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_q <= '0;
      ce_q     <= 1'b0;
    end else if (load_en) begin
      timing_q <= timing_d;
      ce_q     <= ce_d;
    end
  end

  assign timing_word = timing_q;
  assign ce_force    = ce_q;

endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
  import nand_strobe_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int DATA_W  = 8,
  localparam int TIMING_W = 2 * SLOTS_PER_GROUP * FIELD_W,
  localparam int WAIT_W   = FIELD_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic [TIMING_W-1:0] timing_word,
  input  logic                req_valid,
  input  logic [1:0]          req_kind,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W-1:0]   dq_in,
  output logic                busy,
  output logic                in_cycle,
  output logic                cle,
  output logic                ale,
  output logic                we_n,
  output logic                re_n,
  output logic [DATA_W-1:0]   dq_out,
  output logic                dq_oe,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_valid
);

  function automatic logic [FIELD_W-1:0] pick_field(
    input logic [TIMING_W-1:0] w, input logic is_wr, input int slot);
    int idx;
    idx = (is_wr ? SLOTS_PER_GROUP : 0) + slot;
    return w[idx*FIELD_W +: FIELD_W];
  endfunction

  phase_e              phase_q, phase_d;
  cyc_kind_e           kind_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [FIELD_W-1:0]  cnt_q, cnt_d;
  logic [WAIT_W-1:0]   wcnt_q, wcnt_d;
  logic [FIELD_W-1:0]  hold_q, width_q, delay_q;
  logic [FIELD_W-1:0]  new_setup, new_hold, new_width, new_delay;
  logic [DATA_W-1:0]   rd_data_q;
  logic                rd_valid_q;
  logic                accept, cap_en;
  logic                req_is_wr;
  cyc_kind_e           req_kind_e;

  assign req_kind_e = cyc_kind_e'(req_kind);
  assign req_is_wr  = !kind_is_read(req_kind_e);
  assign new_setup  = pick_field(timing_word, req_is_wr, SLOT_SETUP);
  assign new_hold   = pick_field(timing_word, req_is_wr, SLOT_HOLD);
  assign new_width  = pick_field(timing_word, req_is_wr, SLOT_WIDTH);
  assign new_delay  = pick_field(timing_word, req_is_wr, SLOT_DELAY);

  assign accept = (phase_q == PH_IDLE) && req_valid && !soft_rst;

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    wcnt_d  = wcnt_q;
    cap_en  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          phase_d = PH_SETUP;
          cnt_d   = new_setup;
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_PULSE;
          cnt_d   = width_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_PULSE: begin
        if (cnt_q == '0) begin
          phase_d = PH_HOLD;
          cnt_d   = hold_q;
          cap_en  = kind_is_read(kind_q);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          if (delay_q == '0) begin
            phase_d = PH_IDLE;
          end else begin
            phase_d = PH_WAIT;
            wcnt_d  = {delay_q, 1'b0} - WAIT_W'(1);
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_WAIT: begin
        if (wcnt_q == '0) phase_d = PH_IDLE;
        else              wcnt_d  = wcnt_q - 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
    if (soft_rst) begin
      phase_d = PH_IDLE;
      cap_en  = 1'b0;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wcnt_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      wcnt_q  <= wcnt_d;
    end
  end

  // Request capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= KIND_CMD;
      wdata_q <= '0;
      hold_q  <= '0;
      width_q <= '0;
      delay_q <= '0;
    end else if (accept) begin
      kind_q  <= req_kind_e;
      wdata_q <= req_wdata;
      hold_q  <= new_hold;
      width_q <= new_width;
      delay_q <= new_delay;
    end
  end

  // Read data capture on the edge that ends the pulse phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
    end else if (cap_en) begin
      rd_data_q <= dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= cap_en;
  end

  // Outputs decoded from registered state
  logic strobe_phase, kind_wr;
  assign kind_wr      = !kind_is_read(kind_q);
  assign in_cycle     = (phase_q == PH_SETUP) || (phase_q == PH_PULSE) || (phase_q == PH_HOLD);
  assign strobe_phase = (phase_q == PH_PULSE);
  assign busy         = (phase_q != PH_IDLE);
  assign cle          = in_cycle && (kind_q == KIND_CMD);
  assign ale          = in_cycle && (kind_q == KIND_ADDR);
  assign we_n         = !(strobe_phase && kind_wr);
  assign re_n         = !(strobe_phase && !kind_wr);
  assign dq_oe        = in_cycle && kind_wr;
  assign dq_out       = wdata_q;
  assign rd_data      = rd_data_q;
  assign rd_valid     = rd_valid_q;

endmodule

// File: rtl/nand_strobe_engine.sv
module nand_strobe_engine
  import nand_strobe_pkg::*;
#(
  parameter int FIELD_W     = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  localparam int TIMING_W   = 2 * SLOTS_PER_GROUP * FIELD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                cfg_wr,
  input  logic [TIMING_W-1:0] cfg_timing,
  input  logic                cfg_ce_force,
  input  logic                req_valid,
  input  logic [1:0]          req_kind,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                busy,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_valid,
  output logic                dev_ready,
  output logic                nand_ce_n,
  output logic                nand_cle,
  output logic                nand_ale,
  output logic                nand_we_n,
  output logic                nand_re_n,
  output logic [DATA_W-1:0]   nand_dq_out,
  output logic                nand_dq_oe,
  input  logic [DATA_W-1:0]   nand_dq_in,
  input  logic                nand_rb
);

  logic                core_rst_n;
  logic [TIMING_W-1:0] timing_word;
  logic                ce_force;
  logic                in_cycle;

  // Reset: asserted asynchronously, released through a synchronizer
  nand_sync_chain #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (1'b1),
    .sync_out (core_rst_n)
  );

  nand_timing_regs #(.TIMING_W(TIMING_W)) u_regs (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .soft_rst     (soft_rst),
    .cfg_wr       (cfg_wr),
    .cfg_timing   (cfg_timing),
    .cfg_ce_force (cfg_ce_force),
    .timing_word  (timing_word),
    .ce_force     (ce_force)
  );

  nand_phase_fsm #(.FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .soft_rst    (soft_rst),
    .timing_word (timing_word),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_wdata   (req_wdata),
    .dq_in       (nand_dq_in),
    .busy        (busy),
    .in_cycle    (in_cycle),
    .cle         (nand_cle),
    .ale         (nand_ale),
    .we_n        (nand_we_n),
    .re_n        (nand_re_n),
    .dq_out      (nand_dq_out),
    .dq_oe       (nand_dq_oe),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid)
  );

  nand_sync_chain #(.STAGES(SYNC_STAGES)) u_rb_sync (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .async_in (nand_rb),
    .sync_out (dev_ready)
  );

  assign nand_ce_n = !(ce_force || in_cycle);

endmodule

// File: rtl/nand_strobe_engine_chk.sv
module nand_strobe_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic req_valid,
  input logic busy,
  input logic rd_valid,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_dq_oe
);

  assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  assert_latch_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle || nand_ale) |-> (!(nand_cle && nand_ale) && nand_dq_oe && !nand_ce_n));

  assert_write_drives_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);

  assert_read_bus_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe));

  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!nand_re_n) && nand_re_n));

  assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_busy_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  assert_soft_rst_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && !rd_valid));

endmodule

bind nand_strobe_engine nand_strobe_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .req_valid  (req_valid),
  .busy       (busy),
  .rd_valid   (rd_valid),
  .nand_ce_n  (nand_ce_n),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_oe (nand_dq_oe)
);

// File: tb/sim_nand_strobe_engine.sv
`timescale 1ns/1ps
module sim_nand_strobe_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_timing = '0;
  logic        cfg_ce_force = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [7:0]  req_wdata = '0;
  logic        busy;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        dev_ready;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic [7:0]  nand_dq_out;
  logic        nand_dq_oe;
  logic [7:0]  nand_dq_in = '0;
  logic        nand_rb = 1'b1;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  nand_strobe_engine u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
    .cfg_timing(cfg_timing), .cfg_ce_force(cfg_ce_force),
    .req_valid(req_valid), .req_kind(req_kind), .req_wdata(req_wdata),
    .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid), .dev_ready(dev_ready),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int rs, rh, rw, rd, ws, wh, ww, wd);
    return {wd[3:0], ww[3:0], wh[3:0], ws[3:0], rd[3:0], rw[3:0], rh[3:0], rs[3:0]};
  endfunction

  task automatic do_cfg(input logic [31:0] t, input logic ce);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_timing = t; cfg_ce_force = ce;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Runs one cycle and classifies each negedge sample by phase.
  task automatic run_cycle(input logic [1:0] kind, input logic [7:0] wd,
                           input logic [7:0] rdin, input bit inject,
                           output int s, output int p, output int h,
                           output int w, output int rdv, output int lerr,
                           output int first_busy);
    int ph;
    logic is_rd;
    s = 0; p = 0; h = 0; w = 0; rdv = 0; lerr = 0; ph = 0;
    is_rd = (kind == 2'b11);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_wdata = wd; nand_dq_in = rdin;
    @(negedge clk);
    req_valid = 1'b0;
    first_busy = busy;
    for (int n = 0; n < 200; n++) begin
      if (!busy) break;
      if (rd_valid) rdv++;
      if (!nand_we_n && !nand_re_n) lerr++;
      if (is_rd ? !nand_we_n : !nand_re_n) lerr++;
      if (!nand_ce_n) begin
        if (nand_cle != (kind == 2'b00)) lerr++;
        if (nand_ale != (kind == 2'b01)) lerr++;
        if (nand_dq_oe != !is_rd) lerr++;
        if (!is_rd && nand_dq_out != wd) lerr++;
        if ((is_rd ? nand_re_n : nand_we_n) == 1'b0) begin
          p++; ph = 1;
        end else if (ph == 0) s++;
        else h++;
      end else begin
        if (nand_cle || nand_ale || nand_dq_oe || !nand_we_n || !nand_re_n) lerr++;
        w++;
      end
      if (inject && n == 1) begin
        req_valid = 1'b1; req_kind = 2'b00; req_wdata = ~wd;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11", "busy", busy, 0);
    chk("R11", "we_n", nand_we_n, 1);
    chk("R11", "re_n", nand_re_n, 1);
    chk("R11", "cle|ale", nand_cle | nand_ale, 0);
    chk("R11", "dq_oe", nand_dq_oe, 0);
    chk("R11", "ce_n", nand_ce_n, 1);
    chk("R11", "rd_valid", rd_valid, 0);
  endtask

  task automatic t_read_timing();
    int s, p, h, w, rdv, le, fb;
    do_cfg(mk(2, 1, 3, 2, 5, 4, 6, 1), 1'b0);
    run_cycle(2'b11, 8'h00, 8'hA5, 1'b0, s, p, h, w, rdv, le, fb);
    chk("R7", "read accepted", fb, 1);
    chk("R1", "read setup", s, 3);
    chk("R1", "read pulse", p, 4);
    chk("R1", "read hold", h, 2);
    chk("R3", "read delay", w, 4);
    chk("R5", "read strobe/line errors", le, 0);
    chk("R6", "rd_valid pulses", rdv, 1);
    chk("R6", "rd_data", rd_data, 8'hA5);
  endtask

  task automatic t_write_timing();
    int s, p, h, w, rdv, le, fb;
    do_cfg(mk(2, 1, 3, 2, 5, 4, 6, 1), 1'b0);
    run_cycle(2'b10, 8'h3C, 8'h00, 1'b0, s, p, h, w, rdv, le, fb);
    chk("R2", "write setup", s, 6);
    chk("R2", "write pulse", p, 7);
    chk("R2", "write hold", h, 5);
    chk("R3", "write delay", w, 2);
    chk("R4", "write line errors", le, 0);
    chk("R6", "no rd_valid on write", rdv, 0);
  endtask

  task automatic t_cmd_addr();
    int s, p, h, w, rdv, le, fb;
    do_cfg(mk(0, 0, 0, 0, 1, 0, 2, 0), 1'b0);
    run_cycle(2'b00, 8'h70, 8'h00, 1'b0, s, p, h, w, rdv, le, fb);
    chk("R4", "cmd lines", le, 0);
    chk("R2", "cmd phases s+p+h", s * 100 + p * 10 + h, 231);
    chk("R3", "zero delay", w, 0);
    run_cycle(2'b01, 8'h12, 8'h00, 1'b0, s, p, h, w, rdv, le, fb);
    chk("R4", "addr lines", le, 0);
    chk("R2", "addr phases s+p+h", s * 100 + p * 10 + h, 231);
  endtask

  task automatic t_extremes();
    int s, p, h, w, rdv, le, fb;
    do_cfg(mk(15, 15, 15, 15, 0, 0, 0, 0), 1'b0);
    run_cycle(2'b11, 8'h00, 8'h5A, 1'b0, s, p, h, w, rdv, le, fb);
    chk("R1", "max setup", s, 16);
    chk("R1", "max pulse", p, 16);
    chk("R1", "max hold", h, 16);
    chk("R3", "max delay", w, 30);
    run_cycle(2'b10, 8'hFF, 8'h00, 1'b0, s, p, h, w, rdv, le, fb);
    chk("R2", "min phases s+p+h", s * 100 + p * 10 + h, 111);
    chk("R3", "min delay", w, 0);
  endtask

  task automatic t_busy_ignore();
    int s, p, h, w, rdv, le, fb;
    do_cfg(mk(0, 0, 0, 0, 2, 2, 2, 1), 1'b0);
    run_cycle(2'b10, 8'hC3, 8'h00, 1'b1, s, p, h, w, rdv, le, fb);
    chk("R7", "phases unchanged", s * 1000 + p * 100 + h * 10 + w, 3332);
    chk("R7", "no cmd line or data change", le, 0);
    chk("R7", "still idle after", busy, 0);
    @(negedge clk);
    chk("R7", "no second cycle", busy, 0);
  endtask

  task automatic t_ce_force();
    do_cfg(32'h0, 1'b1);
    @(negedge clk);
    chk("R8", "ce held low idle", nand_ce_n, 0);
    do_cfg(32'h0, 1'b0);
    @(negedge clk);
    chk("R8", "ce released", nand_ce_n, 1);
  endtask

  task automatic t_ready();
    @(negedge clk); nand_rb = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "busy pin", dev_ready, 0);
    nand_rb = 1'b1;
    @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R9", "ready pin", dev_ready, 1);
  endtask

  task automatic t_soft_reset();
    int s, p, h, w, rdv, le, fb;
    do_cfg(32'hFFFF_FFFF, 1'b1);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b10; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10", "busy before soft reset", busy, 1);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R10", "idle after soft reset", busy, 0);
    chk("R10", "ce hold cleared", nand_ce_n, 1);
    chk("R10", "we_n high", nand_we_n, 1);
    run_cycle(2'b11, 8'h00, 8'h11, 1'b0, s, p, h, w, rdv, le, fb);
    chk("R10", "timing cleared", s * 1000 + p * 100 + h * 10 + w, 1110);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read_timing();
    t_write_timing();
    t_cmd_addr();
    t_extremes();
    t_busy_ignore();
    t_ce_force();
    t_ready();
    t_soft_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule